// File: doc/BRIEF.md
# Stopwatch Control Sequencer with Lap Hold

This block is the control state machine of a stopwatch. Two momentary push-buttons go in: a start/stop button and a lap/clear button. Three control levels come out, and they drive a separate time counter and its display. `run` lets the counter advance, `clear` zeroes it and `latch` freezes the value shown on the display. The block holds no count of its own.

In regular mode the start/stop button starts and halts the count. When the count is halted, the lap/clear button zeroes it. When the count is running, the lap/clear button enters lap mode. In lap mode the display stays frozen on the value captured at entry, and the count goes on underneath. The count can still be halted and restarted inside lap mode. A second lap/clear press leaves lap mode, drops the freeze and keeps the current run or halt condition.

The machine has fourteen states: six resting states and eight press-tracking states. A press-tracking state waits for its button to be released, so holding a button for any number of clocks acts as a single press. The outputs are decoded from the state alone. A parameter selects a binary or a one-hot state register, and another selects the button polarity.

Top module: `stopwatch_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are run=0, clear=1, latch=0. If both buttons are released at the first edge with `rst` low, the outputs go to run=0, clear=0, latch=0. Clear is therefore high for exactly one cycle after reset.
- R2: The buttons are active-low: 0 means pressed and 1 means released. A button held pressed over many edges causes one state change only. The outputs keep their value until the button reads 1.
- R3: Pressing start/stop while the count is halted or cleared sets run=1 from the edge that first samples the press. Run stays 1 after the release.
- R4: Pressing start/stop while running in regular mode sets run=0 from the edge that samples the press.
- R5: Pressing lap/clear while halted or cleared sets clear=1 with run=0 and latch=0. Clear stays high while the button is held and returns to 0 at the edge that samples the release. Clear is never high together with run or latch.
- R6: Pressing lap/clear while running in regular mode sets latch=1 and keeps run=1.
- R7: While latch=1, each start/stop press toggles run and keeps latch=1.
- R8: While latch=1, a lap/clear press sets latch=0 and keeps run at its value from before the press.
- R9: If both buttons are first sampled pressed at the same edge in a resting regular state, start/stop wins. If lap/clear is still held once the start/stop press has settled, it is acted on afterwards.
- R10: With the one-hot state register, the output sequence is identical to the sequence with the binary state register.
- R11: The outputs are a pure function of the registered state. A button change shows at the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes at its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Start/stop button, 0 = pressed |
| lap_n | input | 1 | Lap/clear button, 0 = pressed |
| run | output | 1 | Count enable for the time counter |
| clear | output | 1 | Zeroes the time counter |
| latch | output | 1 | Freezes the displayed value |

## Verification
The bench holds each button for several clocks. A design that left a press-tracking state without waiting for the release would toggle run repeatedly, or fall out of lap mode. Both buttons are pressed together while running. A wrong priority would enter lap mode instead of halting. The bench also releases one button while the other is still held, and a machine that dropped or doubled that second press would show the wrong clear or latch cycle. Lap mode is left both from its running and from its halted branch, which catches a return that restores the wrong run level or leaves latch high. Reset is applied while the count is running, and a design with the wrong reset state would miss the single clear cycle. A second instance with the one-hot register is checked against the same expected sequence.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;

   localparam int SW_NUM_STATES = 14;
   localparam int SW_STATE_W    = $clog2(SW_NUM_STATES);

   // resting: STOPPED RUNNING CLEARED LAP_RUN LAP_STOP LAP_RESUMED
   // press-tracking: the remaining eight
   typedef enum logic [SW_STATE_W-1:0] {
      ST_STOPPED     = 4'd0,
      ST_GO_WAIT     = 4'd1,
      ST_RUNNING     = 4'd2,
      ST_HALT_WAIT   = 4'd3,
      ST_CLR_WAIT    = 4'd4,
      ST_CLEARED     = 4'd5,
      ST_LAP_ENTER   = 4'd6,
      ST_LAP_RUN     = 4'd7,
      ST_LAP_HALT    = 4'd8,
      ST_LAP_STOP    = 4'd9,
      ST_LAP_GO      = 4'd10,
      ST_LAP_RESUMED = 4'd11,
      ST_RET_RUN     = 4'd12,
      ST_RET_STOP    = 4'd13
   } sw_state_e;

   typedef struct packed {
      logic run;
      logic clear;
      logic latch;
   } sw_ctl_t;

   localparam sw_state_e SW_RESET_STATE = ST_CLR_WAIT;

endpackage

// File: rtl/sw_btn_decode.sv
module sw_btn_decode #(
   parameter int ACTIVE_LOW = 1
) (
   input  logic start_btn,
   input  logic lap_btn,
   output logic start_pr,
   output logic lap_pr
);

   generate
      if (ACTIVE_LOW != 0) begin : g_low
         assign start_pr = ~start_btn;
         assign lap_pr   = ~lap_btn;
      end else begin : g_high
         assign start_pr = start_btn;
         assign lap_pr   = lap_btn;
      end
   endgenerate

endmodule

// File: rtl/sw_next_state.sv
module sw_next_state
   import sw_ctrl_pkg::*;
(
   input  sw_state_e cur,
   input  logic      start_pr,
   input  logic      lap_pr,
   output sw_state_e nxt
);

   always_comb begin
      nxt = cur;
      case (cur)
         ST_STOPPED, ST_CLEARED: begin
            if (start_pr)    nxt = ST_GO_WAIT;
            else if (lap_pr) nxt = ST_CLR_WAIT;
         end
         ST_GO_WAIT:   if (!start_pr) nxt = ST_RUNNING;
         ST_RUNNING: begin
            if (start_pr)    nxt = ST_HALT_WAIT;
            else if (lap_pr) nxt = ST_LAP_ENTER;
         end
         ST_HALT_WAIT: if (!start_pr) nxt = ST_STOPPED;
         ST_CLR_WAIT:  if (!lap_pr)   nxt = ST_CLEARED;
         ST_LAP_ENTER: if (!lap_pr)   nxt = ST_LAP_RUN;
         ST_LAP_RUN, ST_LAP_RESUMED: begin
            if (start_pr)    nxt = ST_LAP_HALT;
            else if (lap_pr) nxt = ST_RET_RUN;
         end
         ST_LAP_HALT:  if (!start_pr) nxt = ST_LAP_STOP;
         ST_LAP_STOP: begin
            if (start_pr)    nxt = ST_LAP_GO;
            else if (lap_pr) nxt = ST_RET_STOP;
         end
         ST_LAP_GO:    if (!start_pr) nxt = ST_LAP_RESUMED;
         ST_RET_RUN:   if (!lap_pr)   nxt = ST_RUNNING;
         ST_RET_STOP:  if (!lap_pr)   nxt = ST_STOPPED;
         default:      nxt = SW_RESET_STATE;
      endcase
   end

endmodule

// File: rtl/sw_state_reg.sv
module sw_state_reg
   import sw_ctrl_pkg::*;
#(
   parameter int ONE_HOT = 0
) (
   input  logic      clk,
   input  logic      rst,
   input  sw_state_e nxt,
   output sw_state_e cur
);

   generate
      if (ONE_HOT == 0) begin : g_bin
         sw_state_e st_q;
         always_ff @(posedge clk) begin
            if (rst) st_q <= SW_RESET_STATE;
            else     st_q <= nxt;
         end
         assign cur = st_q;
      end else begin : g_hot
         logic [SW_NUM_STATES-1:0] hot_q;
         logic [SW_NUM_STATES-1:0] hot_d;
         logic [SW_NUM_STATES-1:0] hot_rst;
         logic [SW_STATE_W-1:0]    idx;

         always_comb begin
            hot_d = '0;
            hot_d[nxt] = 1'b1;
            hot_rst = '0;
            hot_rst[SW_RESET_STATE] = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst) hot_q <= hot_rst;
            else     hot_q <= hot_d;
         end

         always_comb begin
            idx = '0;
            for (int i = 0; i < SW_NUM_STATES; i++) begin
               if (hot_q[i]) idx = idx | SW_STATE_W'(i);
            end
         end
         assign cur = sw_state_e'(idx);
      end
   endgenerate

endmodule

// File: rtl/sw_out_decode.sv
module sw_out_decode
   import sw_ctrl_pkg::*;
(
   input  sw_state_e cur,
   output sw_ctl_t   ctl
);

   always_comb begin
      ctl = '0;
      case (cur)
         ST_GO_WAIT, ST_RUNNING, ST_RET_RUN:          ctl.run = 1'b1;
         ST_CLR_WAIT:                                 ctl.clear = 1'b1;
         ST_LAP_ENTER, ST_LAP_RUN, ST_LAP_GO,
         ST_LAP_RESUMED: begin
            ctl.run   = 1'b1;
            ctl.latch = 1'b1;
         end
         ST_LAP_HALT, ST_LAP_STOP:                    ctl.latch = 1'b1;
         default:                                     ctl = '0;
      endcase
   end

endmodule

// File: rtl/stopwatch_ctrl.sv
module stopwatch_ctrl
   import sw_ctrl_pkg::*;
#(
   parameter int STATE_ENC      = 0,
   parameter int BTN_ACTIVE_LOW = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic start_n,
   input  logic lap_n,
   output logic run,
   output logic clear,
   output logic latch
);

   initial begin : p_param_chk
      if (STATE_ENC < 0 || STATE_ENC > 1)
         $fatal(1, "stopwatch_ctrl: STATE_ENC must be 0 or 1");
      if (BTN_ACTIVE_LOW < 0 || BTN_ACTIVE_LOW > 1)
         $fatal(1, "stopwatch_ctrl: BTN_ACTIVE_LOW must be 0 or 1");
   end

   logic      start_pr;
   logic      lap_pr;
   sw_state_e cur;
   sw_state_e nxt;
   sw_ctl_t   ctl;

   sw_btn_decode #(.ACTIVE_LOW(BTN_ACTIVE_LOW)) u_btn (
      .start_btn (start_n),
      .lap_btn   (lap_n),
      .start_pr  (start_pr),
      .lap_pr    (lap_pr)
   );

   sw_next_state u_nxt (
      .cur      (cur),
      .start_pr (start_pr),
      .lap_pr   (lap_pr),
      .nxt      (nxt)
   );

   sw_state_reg #(.ONE_HOT(STATE_ENC)) u_reg (
      .clk (clk),
      .rst (rst),
      .nxt (nxt),
      .cur (cur)
   );

   sw_out_decode u_out (
      .cur (cur),
      .ctl (ctl)
   );

   assign run   = ctl.run;
   assign clear = ctl.clear;
   assign latch = ctl.latch;

endmodule

// File: rtl/sw_ctrl_chk.sv
module sw_ctrl_chk #(
   parameter int ACTIVE_LOW = 1
) (
   input logic clk,
   input logic rst,
   input logic start_n,
   input logic lap_n,
   input logic run,
   input logic clear,
   input logic latch
);

   logic s_pr;
   logic l_pr;
   assign s_pr = (ACTIVE_LOW != 0) ? ~start_n : start_n;
   assign l_pr = (ACTIVE_LOW != 0) ? ~lap_n   : lap_n;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (clear && !run && !latch));

   // R2
   held_start_chk: assert property (@(posedge clk) disable iff (rst)
      (s_pr && $past(s_pr) && $past(s_pr, 2) && !l_pr && !$past(l_pr)
       && !$past(l_pr, 2) && !$past(rst) && !$past(rst, 2))
      |=> $stable({run, clear, latch}));

   // R2
   held_lap_chk: assert property (@(posedge clk) disable iff (rst)
      (l_pr && $past(l_pr) && $past(l_pr, 2) && !s_pr && !$past(s_pr)
       && !$past(s_pr, 2) && !$past(rst) && !$past(rst, 2))
      |=> $stable({run, clear, latch}));

   // R3
   start_go_chk: assert property (@(posedge clk) disable iff (rst)
      (!run && !clear && !latch && s_pr && !$past(s_pr) && !$past(l_pr))
      |=> (run && !latch));

   // R4
   start_halt_chk: assert property (@(posedge clk) disable iff (rst)
      (run && !latch && s_pr && !$past(s_pr) && !$past(l_pr))
      |=> (!run && !latch));

   // R5
   clear_alone_chk: assert property (@(posedge clk) disable iff (rst)
      clear |-> (!run && !latch));

   // R6
   lap_enter_chk: assert property (@(posedge clk) disable iff (rst)
      (run && !latch && l_pr && !$past(l_pr) && !s_pr && !$past(s_pr))
      |=> (run && latch));

   // R7
   lap_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      (latch && s_pr && !$past(s_pr) && !l_pr && !$past(l_pr))
      |=> (latch && (run != $past(run))));

   // R8
   lap_leave_chk: assert property (@(posedge clk) disable iff (rst)
      (latch && l_pr && !$past(l_pr) && !s_pr && !$past(s_pr))
      |=> (!latch && (run == $past(run))));

   // R9
   both_press_chk: assert property (@(posedge clk) disable iff (rst)
      (run && !latch && s_pr && l_pr && !$past(s_pr) && !$past(l_pr))
      |=> (!latch && !run));

endmodule

bind stopwatch_ctrl sw_ctrl_chk #(.ACTIVE_LOW(BTN_ACTIVE_LOW)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start_n (start_n),
   .lap_n   (lap_n),
   .run     (run),
   .clear   (clear),
   .latch   (latch)
);

// File: tb/tb_stopwatch_ctrl.sv
`timescale 1ns/1ps
module tb_stopwatch_ctrl;

   localparam logic [2:0] O_IDLE  = 3'b000; // {run,clear,latch}
   localparam logic [2:0] O_CLR   = 3'b010;
   localparam logic [2:0] O_RUN   = 3'b100;
   localparam logic [2:0] O_LRUN  = 3'b101;
   localparam logic [2:0] O_LSTOP = 3'b001;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_n = 1'b1;
   logic lap_n = 1'b1;
   logic run, clear, latch;
   logic run_h, clear_h, latch_h;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   stopwatch_ctrl #(.STATE_ENC(0)) dut (
      .clk(clk), .rst(rst), .start_n(start_n), .lap_n(lap_n),
      .run(run), .clear(clear), .latch(latch)
   );

   stopwatch_ctrl #(.STATE_ENC(1)) dut_hot (
      .clk(clk), .rst(rst), .start_n(start_n), .lap_n(lap_n),
      .run(run_h), .clear(clear_h), .latch(latch_h)
   );

   // driver: inputs for one edge, expected outputs after that edge
   task automatic step(input bit r, input bit sp, input bit lp,
                       input logic [2:0] e, input string tag);
      @(negedge clk);
      rst     = r;
      start_n = ~sp;
      lap_n   = ~lp;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: a quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({run, clear, latch} !== e) begin
               bad++;
               $display("FAIL %s binary got=%b exp=%b", t, {run, clear, latch}, e);
            end
            total++;
            if ({run_h, clear_h, latch_h} !== e) begin
               bad++;
               $display("FAIL R10 %s one-hot got=%b exp=%b", t,
                        {run_h, clear_h, latch_h}, e);
            end
         end
      end
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         done = 1;
         bad++;
         $display("FAIL watchdog expired got=hang exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset gives one clear cycle, then idle
      step(1, 0, 0, O_CLR,  "R1 reset");
      step(0, 0, 0, O_IDLE, "R1 after reset");
      step(0, 0, 0, O_IDLE, "R1 idle");
      // R5 clear while cleared, held
      step(0, 0, 1, O_CLR,  "R5 clear press");
      for (int i = 0; i < 3; i++) step(0, 0, 1, O_CLR, "R5 clear held");
      step(0, 0, 0, O_IDLE, "R5 clear release");
      // R3 start, held long (R2)
      step(0, 1, 0, O_RUN,  "R3 start press");
      for (int i = 0; i < 4; i++) step(0, 1, 0, O_RUN, "R2 start held");
      step(0, 0, 0, O_RUN,  "R3 start release");
      step(0, 0, 0, O_RUN,  "R11 running idle");
      // R4 halt, held (R2)
      step(0, 1, 0, O_IDLE, "R4 halt press");
      for (int i = 0; i < 3; i++) step(0, 1, 0, O_IDLE, "R2 halt held");
      step(0, 0, 0, O_IDLE, "R4 halt release");
      // R3 restart from halted, R4 again
      step(0, 1, 0, O_RUN,  "R3 restart press");
      step(0, 0, 0, O_RUN,  "R3 restart release");
      step(0, 1, 0, O_IDLE, "R4 halt2 press");
      step(0, 0, 0, O_IDLE, "R4 halt2 release");
      // R5 clear from halted
      step(0, 0, 1, O_CLR,  "R5 clear from halted");
      step(0, 0, 0, O_IDLE, "R5 clear done");
      // R3 start, R6 enter lap with long hold
      step(0, 1, 0, O_RUN,  "R3 start");
      step(0, 0, 0, O_RUN,  "R3 start rel");
      step(0, 0, 1, O_LRUN, "R6 lap press");
      for (int i = 0; i < 3; i++) step(0, 0, 1, O_LRUN, "R2 lap held");
      step(0, 0, 0, O_LRUN, "R6 lap release");
      step(0, 0, 0, O_LRUN, "R6 lap idle");
      // R7 halt and restart in lap mode
      step(0, 1, 0, O_LSTOP, "R7 lap halt");
      step(0, 1, 0, O_LSTOP, "R7 lap halt held");
      step(0, 0, 0, O_LSTOP, "R7 lap halt rel");
      step(0, 1, 0, O_LRUN,  "R7 lap go");
      step(0, 0, 0, O_LRUN,  "R7 lap go rel");
      step(0, 1, 0, O_LSTOP, "R7 lap halt again");
      step(0, 0, 0, O_LSTOP, "R7 lap halt again rel");
      // R8 leave lap from halted branch
      step(0, 0, 1, O_IDLE, "R8 leave halted");
      step(0, 0, 1, O_IDLE, "R8 leave halted held");
      step(0, 0, 0, O_IDLE, "R8 leave halted rel");
      step(0, 1, 0, O_RUN,  "R8 regular start after lap");
      step(0, 0, 0, O_RUN,  "R8 regular start rel");
      // R8 leave lap from running branch
      step(0, 0, 1, O_LRUN, "R6 lap enter2");
      step(0, 0, 0, O_LRUN, "R6 lap enter2 rel");
      step(0, 0, 1, O_RUN,  "R8 leave running");
      step(0, 0, 0, O_RUN,  "R8 leave running rel");
      // R9 both pressed while running
      step(0, 1, 1, O_IDLE, "R9 both press");
      step(0, 1, 1, O_IDLE, "R9 both held");
      step(0, 0, 1, O_IDLE, "R9 start released");
      step(0, 0, 1, O_CLR,  "R9 lap acted after");
      step(0, 0, 0, O_IDLE, "R9 lap released");
      // R2 other button pressed during a held press
      step(0, 1, 0, O_RUN,  "R3 start3");
      step(0, 0, 0, O_RUN,  "R3 start3 rel");
      step(0, 0, 1, O_LRUN, "R6 lap enter3");
      step(0, 1, 1, O_LRUN, "R2 start during lap hold");
      step(0, 1, 0, O_LRUN, "R2 lap released start held");
      step(0, 1, 0, O_LSTOP, "R7 held start acted");
      step(0, 0, 0, O_LSTOP, "R7 release");
      step(0, 0, 1, O_IDLE, "R8 leave3");
      step(0, 0, 0, O_IDLE, "R8 leave3 rel");
      // R1 reset while running
      step(0, 1, 0, O_RUN,  "R3 start4");
      step(0, 0, 0, O_RUN,  "R3 start4 rel");
      step(1, 1, 0, O_CLR,  "R1 reset mid-run");
      step(0, 0, 0, O_IDLE, "R1 after mid-run reset");
      step(0, 0, 0, O_IDLE, "R1 idle after reset");
      @(negedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule